// File: doc/BRIEF.md
# LIN Frame Descriptor Write Sequencer

This block collects a LIN frame descriptor through a single byte-wide write port. An internal write pointer steers each accepted byte into the next descriptor field, in a fixed order. The first write is identifier and parity. The second is frame length. The third holds the checksum and direction controls plus the receive timeout. Every later write is a transmit data byte. The captured descriptor is presented in parallel to a LIN protocol engine. A one-cycle start pulse tells the engine when the descriptor is complete.

The protected identifier carries two parity bits. They come from the written byte when automatic parity is off. When it is on, the block computes them from the identifier. The write pointer returns to the first field on reset and whenever the engine reports idle, a finished frame, or entry into stop mode. Writes past the end of the descriptor are dropped and raise a sticky overrun flag.

Top module: `lin_desc_seq`

## Requirements
- R1: Write 0 stores identifier = wr_data[5:0] and supplied parity = wr_data[7:6]. Each accepted write advances `wr_idx` by one.
- R2: Write 1 stores the length from wr_data[3:0]. `frm_len` shows that value clamped to MAX_DATA (8 by default).
- R3: Write 2 stores the control fields, with these bit positions: `cks_enh` = bit 7 (1 enhanced, 0 classic), `cks_en` = bit 6, `crc_en` = bit 5, `dir_tx` = bit 4 (1 transmit, 0 receive), `rx_timeout` = bits 3:0.
- R4: When `dir_tx` is 1, write 3+i stores data byte i in `tx_data[8*i +: 8]`, for i below `frm_len`.
- R5: When `auto_par_en` is 1, pid[6] = id0^id1^id2^id4 and pid[7] = ~(id1^id3^id4^id5), with pid[5:0] = identifier.
- R6: When `auto_par_en` is 0, pid[7:6] equals the supplied parity from write 0.
- R7: For a receive frame (bit 4 of write 2 is 0), `start_pulse` is high for exactly the one cycle after write 2.
- R8: For a transmit frame, `start_pulse` is high for one cycle after the write of the last data byte. If the length is 0, it is high after write 2 instead.
- R9: A write beyond the expected count changes no field and does not move `wr_idx`. It sets `overrun`, which stays set until the pointer is cleared.
- R10: A high level on `eng_idle`, `frame_done` or `stop_req` clears `wr_idx` and `overrun` at the next edge. A write in that same cycle is discarded. Fields already captured are kept.
- R11: After reset, every output is 0, except `pid` when parity is automatic.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the descriptor register |
| wr_data | input | BYTE_W | Write byte |
| auto_par_en | input | 1 | 1 selects computed identifier parity |
| eng_idle | input | 1 | Engine held idle; clears the pointer |
| frame_done | input | 1 | Frame-complete event; clears the pointer |
| stop_req | input | 1 | Stop-mode entry; clears the pointer |
| pid | output | 8 | Protected identifier {parity, identifier} |
| frm_len | output | 4 | Effective data byte count |
| cks_enh | output | 1 | Checksum model, 1 enhanced |
| cks_en | output | 1 | Checksum byte enable |
| crc_en | output | 1 | Enhanced frame with CRC enable |
| dir_tx | output | 1 | 1 transmit, 0 receive |
| rx_timeout | output | 4 | Receive frame timeout value |
| tx_data | output | MAX_DATA*8 | Transmit data bytes, byte i at bits 8i+7:8i |
| wr_idx | output | CNT_W | Current write pointer |
| start_pulse | output | 1 | One-cycle descriptor-complete strobe |
| overrun | output | 1 | Sticky excess-write flag |

## Verification
The assertions are checked on every cycle. They cover four things: clearing by any of the three events, the single-cycle nature of the start strobe, the stickiness of overrun and the freeze of fields under excess writes, and the automatic parity relation on the identifier. They also check that the header writes step the pointer by one. Only the bench's scenarios can show some behaviours, because they need a complete write history. These are the field bit positions, the clamping of long lengths, the placement of each data byte, the exact write that ends transmit and receive descriptors, and the discarding of a write that collides with a clear.

// File: rtl/lin_desc_pkg.sv
package lin_desc_pkg;

   localparam int SLOT_PID  = 0;
   localparam int SLOT_LEN  = 1;
   localparam int SLOT_CTRL = 2;
   localparam int SLOT_DATA = 3;

   typedef struct packed {
      logic       cks_enh;
      logic       cks_en;
      logic       crc_en;
      logic       dir_tx;
      logic [3:0] tmo;
   } ctrl_t;

   function automatic logic [1:0] lin_auto_par(input logic [5:0] id);
      logic p0;
      logic p1;
      p0 = id[0] ^ id[1] ^ id[2] ^ id[4];
      p1 = ~(id[1] ^ id[3] ^ id[4] ^ id[5]);
      return {p1, p0};
   endfunction

endpackage

// File: rtl/lin_ptr_ctrl.sv
module lin_ptr_ctrl #(
   parameter int MAX_DATA = 8,
   parameter int CNT_W    = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic             clr,
   input  logic             dir_now,
   input  logic             dir_q,
   input  logic [3:0]       eff_len,
   output logic [CNT_W-1:0] cnt,
   output logic             accept,
   output logic             start_pulse,
   output logic             overrun
);
   import lin_desc_pkg::*;

   localparam logic [CNT_W-1:0] CTRL_IDX = CNT_W'(SLOT_CTRL);
   localparam logic [CNT_W-1:0] DATA_IDX = CNT_W'(SLOT_DATA);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] limit;
   logic             in_hdr;
   logic             last_hdr;
   logic             last_data;
   logic             start_q;
   logic             ovr_q;

   assign limit     = dir_q ? (DATA_IDX + CNT_W'(eff_len)) : DATA_IDX;
   assign in_hdr    = (cnt_q < DATA_IDX);
   assign accept    = wr_en & ~clr & (in_hdr | (cnt_q < limit));
   assign last_hdr  = (cnt_q == CTRL_IDX) & (~dir_now | (eff_len == 4'd0));
   assign last_data = ~in_hdr & dir_q & (cnt_q == (limit - CNT_W'(1)));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         start_q <= 1'b0;
         ovr_q   <= 1'b0;
      end else if (clr) begin
         cnt_q   <= '0;
         start_q <= 1'b0;
         ovr_q   <= 1'b0;
      end else begin
         start_q <= accept & (last_hdr | last_data);
         if (accept) begin
            cnt_q <= cnt_q + CNT_W'(1);
         end else if (wr_en) begin
            ovr_q <= 1'b1;
         end
      end
   end

   assign cnt         = cnt_q;
   assign start_pulse = start_q;
   assign overrun     = ovr_q;

endmodule

// File: rtl/lin_field_cap.sv
module lin_field_cap #(
   parameter int MAX_DATA = 8,
   parameter int CNT_W    = 4,
   parameter int BYTE_W   = 8
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       accept,
   input  logic [CNT_W-1:0]           cnt,
   input  logic [BYTE_W-1:0]          wr_data,
   output logic [5:0]                 id,
   output logic [1:0]                 par,
   output logic [3:0]                 eff_len,
   output lin_desc_pkg::ctrl_t        ctrl,
   output logic [MAX_DATA*BYTE_W-1:0] tx_data
);
   import lin_desc_pkg::*;

   logic [5:0] id_q;
   logic [1:0] par_q;
   logic [3:0] len_q;
   ctrl_t      ctrl_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         id_q   <= '0;
         par_q  <= '0;
         len_q  <= '0;
         ctrl_q <= '0;
      end else if (accept) begin
         if (cnt == CNT_W'(SLOT_PID)) begin
            id_q  <= wr_data[5:0];
            par_q <= wr_data[7:6];
         end
         if (cnt == CNT_W'(SLOT_LEN)) begin
            len_q <= wr_data[3:0];
         end
         if (cnt == CNT_W'(SLOT_CTRL)) begin
            ctrl_q <= ctrl_t'(wr_data[7:0]);
         end
      end
   end

   generate
      for (genvar gi = 0; gi < MAX_DATA; gi++) begin : g_byte
         logic [BYTE_W-1:0] byte_q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               byte_q <= '0;
            end else if (accept && (cnt == CNT_W'(SLOT_DATA + gi))) begin
               byte_q <= wr_data;
            end
         end
         assign tx_data[gi*BYTE_W +: BYTE_W] = byte_q;
      end
   endgenerate

   assign eff_len = (len_q > 4'(MAX_DATA)) ? 4'(MAX_DATA) : len_q;
   assign id      = id_q;
   assign par     = par_q;
   assign ctrl    = ctrl_q;

endmodule

// File: rtl/lin_pid_gen.sv
module lin_pid_gen #(
   parameter bit AUTO_PAR_SUPPORT = 1'b1
) (
   input  logic [5:0] id,
   input  logic [1:0] par,
   input  logic       auto_en,
   output logic [7:0] pid
);
   import lin_desc_pkg::*;

   logic [1:0] par_sel;

   generate
      if (AUTO_PAR_SUPPORT) begin : g_auto
         assign par_sel = auto_en ? lin_auto_par(id) : par;
      end else begin : g_fixed
         logic unused_auto;
         assign unused_auto = auto_en;
         assign par_sel     = par;
      end
   endgenerate

   assign pid = {par_sel, id};

endmodule

// File: rtl/lin_desc_seq.sv
module lin_desc_seq #(
   parameter int MAX_DATA         = 8,
   parameter int BYTE_W           = 8,
   parameter bit AUTO_PAR_SUPPORT = 1'b1,
   localparam int CNT_W           = $clog2(MAX_DATA + 4),
   localparam int DATA_W          = MAX_DATA * BYTE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [BYTE_W-1:0] wr_data,
   input  logic              auto_par_en,
   input  logic              eng_idle,
   input  logic              frame_done,
   input  logic              stop_req,
   output logic [7:0]        pid,
   output logic [3:0]        frm_len,
   output logic              cks_enh,
   output logic              cks_en,
   output logic              crc_en,
   output logic              dir_tx,
   output logic [3:0]        rx_timeout,
   output logic [DATA_W-1:0] tx_data,
   output logic [CNT_W-1:0]  wr_idx,
   output logic              start_pulse,
   output logic              overrun
);
   import lin_desc_pkg::*;

   generate
      if (BYTE_W != 8) begin : g_bad_byte
         $error("lin_desc_seq: BYTE_W must be 8");
      end
      if (MAX_DATA < 1 || MAX_DATA > 15) begin : g_bad_max
         $error("lin_desc_seq: MAX_DATA must be within 1..15");
      end
   endgenerate

   logic       clr;
   logic       accept;
   logic [5:0] id;
   logic [1:0] par;
   logic [3:0] eff_len;
   ctrl_t      ctrl;

   assign clr = eng_idle | frame_done | stop_req;

   lin_ptr_ctrl #(.MAX_DATA(MAX_DATA), .CNT_W(CNT_W)) i_ptr (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_en       (wr_en),
      .clr         (clr),
      .dir_now     (wr_data[4]),
      .dir_q       (ctrl.dir_tx),
      .eff_len     (eff_len),
      .cnt         (wr_idx),
      .accept      (accept),
      .start_pulse (start_pulse),
      .overrun     (overrun)
   );

   lin_field_cap #(.MAX_DATA(MAX_DATA), .CNT_W(CNT_W), .BYTE_W(BYTE_W)) i_cap (
      .clk     (clk),
      .rst_n   (rst_n),
      .accept  (accept),
      .cnt     (wr_idx),
      .wr_data (wr_data),
      .id      (id),
      .par     (par),
      .eff_len (eff_len),
      .ctrl    (ctrl),
      .tx_data (tx_data)
   );

   lin_pid_gen #(.AUTO_PAR_SUPPORT(AUTO_PAR_SUPPORT)) i_pid (
      .id      (id),
      .par     (par),
      .auto_en (auto_par_en),
      .pid     (pid)
   );

   assign frm_len    = eff_len;
   assign cks_enh    = ctrl.cks_enh;
   assign cks_en     = ctrl.cks_en;
   assign crc_en     = ctrl.crc_en;
   assign dir_tx     = ctrl.dir_tx;
   assign rx_timeout = ctrl.tmo;

endmodule

// File: rtl/lin_desc_seq_chk.sv
module lin_desc_seq_chk #(
   parameter int CNT_W    = 4,
   parameter int DATA_W   = 64,
   parameter bit AUTO_PAR = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic              auto_par_en,
   input logic              eng_idle,
   input logic              frame_done,
   input logic              stop_req,
   input logic [7:0]        pid,
   input logic [3:0]        frm_len,
   input logic [DATA_W-1:0] tx_data,
   input logic [CNT_W-1:0]  wr_idx,
   input logic              start_pulse,
   input logic              overrun
);
   logic clr_ev;
   assign clr_ev = eng_idle | frame_done | stop_req;

   // R10
   a_r10_clear_ptr: assert property (@(posedge clk) disable iff (!rst_n)
      clr_ev |=> (wr_idx == '0) && !overrun && !start_pulse);

   // R7 / R8
   a_r8_start_single: assert property (@(posedge clk) disable iff (!rst_n)
      start_pulse |=> !start_pulse);

   // R9
   a_r9_ovr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (overrun && !clr_ev) |=> overrun);

   // R9
   a_r9_fields_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !clr_ev && overrun) |=> $stable(tx_data) && $stable(frm_len) && $stable(wr_idx));

   // R1
   a_r1_hdr_step: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !clr_ev && wr_idx < CNT_W'(3)) |=> wr_idx == $past(wr_idx) + CNT_W'(1));

   // R5
   a_r5_auto_parity: assert property (@(posedge clk) disable iff (!rst_n)
      (AUTO_PAR && auto_par_en) |->
         (pid[6] == (pid[0] ^ pid[1] ^ pid[2] ^ pid[4])) &&
         (pid[7] == ~(pid[1] ^ pid[3] ^ pid[4] ^ pid[5])));

endmodule

bind lin_desc_seq lin_desc_seq_chk #(.CNT_W(CNT_W), .DATA_W(DATA_W), .AUTO_PAR(AUTO_PAR_SUPPORT)) i_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .wr_en       (wr_en),
   .auto_par_en (auto_par_en),
   .eng_idle    (eng_idle),
   .frame_done  (frame_done),
   .stop_req    (stop_req),
   .pid         (pid),
   .frm_len     (frm_len),
   .tx_data     (tx_data),
   .wr_idx      (wr_idx),
   .start_pulse (start_pulse),
   .overrun     (overrun)
);

// File: tb/test_lin_desc_seq.sv
`timescale 1ns/1ps
module test_lin_desc_seq;
   localparam int MAXD  = 8;
   localparam int CNT_W = $clog2(MAXD + 4);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic wr_en = 1'b0;
   logic [7:0] wr_data = '0;
   logic auto_par_en = 1'b0;
   logic eng_idle = 1'b0, frame_done = 1'b0, stop_req = 1'b0;
   logic [7:0] pid;
   logic [3:0] frm_len, rx_timeout;
   logic cks_enh, cks_en, crc_en, dir_tx, start_pulse, overrun;
   logic [MAXD*8-1:0] tx_data;
   logic [CNT_W-1:0] wr_idx;

   always #2.5 clk = ~clk;

   lin_desc_seq i_lin_desc_seq (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .auto_par_en(auto_par_en), .eng_idle(eng_idle), .frame_done(frame_done),
      .stop_req(stop_req), .pid(pid), .frm_len(frm_len), .cks_enh(cks_enh),
      .cks_en(cks_en), .crc_en(crc_en), .dir_tx(dir_tx), .rx_timeout(rx_timeout),
      .tx_data(tx_data), .wr_idx(wr_idx), .start_pulse(start_pulse), .overrun(overrun)
   );

   int checks = 0;
   int failures = 0;
   bit finished = 1'b0;

   // reference model state
   bit [5:0] m_id;
   bit [1:0] m_par;
   bit [3:0] m_len;
   bit [7:0] m_ctrl;
   bit [7:0] m_data [MAXD];
   int m_cnt;
   bit m_start, m_ovr;

   function automatic int eff_len();
      return (m_len > MAXD) ? MAXD : int'(m_len);
   endfunction

   function automatic bit [7:0] exp_pid();
      bit [1:0] p;
      if (auto_par_en) begin
         p[0] = m_id[0] ^ m_id[1] ^ m_id[2] ^ m_id[4];
         p[1] = ~(m_id[1] ^ m_id[3] ^ m_id[4] ^ m_id[5]);
      end else begin
         p = m_par;
      end
      return {p, m_id};
   endfunction

   task automatic chk(input string tag, input string what, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s %s actual=0x%0h expected=0x%0h", tag, what, act, exp);
      end
   endtask

   task automatic compare_all(input string tag);
      logic [MAXD*8-1:0] ed;
      for (int i = 0; i < MAXD; i++) ed[i*8 +: 8] = m_data[i];
      chk(tag, "pid", longint'(pid), longint'(exp_pid()));
      chk(tag, "frm_len", longint'(frm_len), longint'(eff_len()));
      chk(tag, "ctrl", longint'({cks_enh, cks_en, crc_en, dir_tx, rx_timeout}), longint'(m_ctrl));
      chk(tag, "tx_data", longint'(tx_data), longint'(ed));
      chk(tag, "wr_idx", longint'(wr_idx), longint'(m_cnt));
      chk(tag, "start_pulse", longint'(start_pulse), longint'(m_start));
      chk(tag, "overrun", longint'(overrun), longint'(m_ovr));
   endtask

   task automatic step(input string tag, input bit wr, input bit [7:0] d,
                       input bit idle = 0, input bit done = 0, input bit stp = 0);
      int el;
      wr_en = wr; wr_data = d; eng_idle = idle; frame_done = done; stop_req = stp;
      el = eff_len();
      if (idle || done || stp) begin
         m_cnt = 0; m_ovr = 0; m_start = 0;
      end else begin
         m_start = 0;
         if (wr) begin
            if (m_cnt == 0) begin m_id = d[5:0]; m_par = d[7:6]; m_cnt = 1; end
            else if (m_cnt == 1) begin m_len = d[3:0]; m_cnt = 2; end
            else if (m_cnt == 2) begin
               m_ctrl = d; m_cnt = 3;
               if (!d[4] || el == 0) m_start = 1;
            end else if (m_ctrl[4] && m_cnt < 3 + el) begin
               m_data[m_cnt-3] = d; m_cnt++;
               if (m_cnt == 3 + el) m_start = 1;
            end else m_ovr = 1;
         end
      end
      @(posedge clk);
      @(negedge clk);
      wr_en = 0; eng_idle = 0; frame_done = 0; stop_req = 0;
      compare_all(tag);
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      checks++; failures++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      m_id = 0; m_par = 0; m_len = 0; m_ctrl = 0; m_cnt = 0; m_start = 0; m_ovr = 0;
      for (int i = 0; i < MAXD; i++) m_data[i] = 0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      compare_all("R11");
      rst_n = 1'b1;
      @(negedge clk);
      compare_all("R11");

      // receive frame, supplied parity
      step("R1", 1, 8'hBC);
      step("R2", 1, 8'h04);
      step("R7", 1, 8'hC5);   // R3: enh, cks on, crc off, rx, tmo 5
      step("R7", 0, 8'h00);
      step("R9", 1, 8'h77);
      step("R9", 0, 8'h00);
      step("R9", 1, 8'h66);
      step("R10", 0, 8'h00, 0, 1, 0);

      // transmit frame, automatic parity, length 3
      auto_par_en = 1'b1;
      step("R5", 1, 8'h3A);
      step("R2", 1, 8'h03);
      step("R3", 1, 8'h70);
      step("R4", 1, 8'h11);
      step("R4", 1, 8'h22);
      step("R8", 1, 8'h33);
      step("R9", 1, 8'h44);
      step("R10", 0, 8'h00, 1, 0, 0);

      // transmit, length 0
      step("R5", 1, 8'h15);
      step("R2", 1, 8'h00);
      step("R8", 1, 8'h10);
      step("R9", 1, 8'h55);
      step("R10", 0, 8'h00, 0, 0, 1);

      // transmit, length 12 clamps to 8
      auto_par_en = 1'b0;
      step("R6", 1, 8'h7F);
      step("R2", 1, 8'h0C);
      step("R3", 1, 8'h90);
      for (int i = 0; i < MAXD; i++) step(i == MAXD-1 ? "R8" : "R4", 1, 8'(8'hA0 + i));
      step("R9", 1, 8'hEE);
      step("R10", 0, 8'h00, 1, 1, 1);

      // clear colliding with a write, and clear mid-sequence
      step("R10", 1, 8'h01, 0, 1, 0);
      step("R1", 1, 8'h42);
      step("R1", 1, 8'h02);
      step("R10", 0, 8'h00, 1, 0, 0);
      step("R1", 1, 8'h81);
      auto_par_en = 1'b1;
      step("R5", 0, 8'h00);
      finish_run();
   end
endmodule